// File: doc/BRIEF.md
# Tri-State Phase Detector with Lock Flag

This block compares two single-cycle strobes in the system clock domain: one marks each edge of the divided reference, and one marks each edge of the divided oscillator (the feedback). It drives the control side of a three-state charge pump with two enables and one drive-enable. When the reference is ahead, it raises a source (positive) pulse. When the feedback is ahead, it raises a sink (negative) pulse. When the two agree, it drives neither and the pump output floats. The detector holds one flag for each side. A strobe sets its flag. When both flags are set, the comparison is finished and both flags clear on the next clock.

A lock monitor measures how long the pump is driven in each comparison. It declares lock after a run of narrow comparisons and drops lock as soon as one pulse grows too wide. The lock indication is active low: it reads 0 when locked. One status pin is shared between this lock indication, an external carrier-detect level and a divider test tap, and control bits choose which one drives it. A power-down input holds the detector idle.

All pins are plain control and status levels. There is no streamed data, so there is no valid/ready handshake. A strobe that arrives is always taken in the cycle it is present.

Top module: `tristate_pfd`

## Requirements
- R1: A feedback strobe that arrives while no comparison is open raises `snk_pulse` from the cycle after that strobe. `snk_pulse` stays high until the cycle after the matching reference strobe.
- R2: A reference strobe that arrives while no comparison is open raises `src_pulse` from the cycle after that strobe. `src_pulse` stays high until the cycle after the matching feedback strobe.
- R3: `drv_en` is high exactly when one of `src_pulse` and `snk_pulse` is high. Strobes on both inputs in the same cycle produce no drive (high impedance).
- R4: In the cycle after a comparison completes, both sides clear. A strobe that arrives in that clearing cycle opens a new comparison.
- R5: Lock is declared after `LOCK_RUNS` (default 4) consecutive comparisons in which the drive lasted at most `MAX_W` (default 2) cycles. The lock indication is 0 when locked and 1 when unlocked.
- R6: When the pump is driven for a cycle beyond `MAX_W` in one comparison, lock drops on the next clock and the run count starts again from zero.
- R7: While `pwr_dn` is high, both pump enables and `drv_en` are low from the next clock, lock is cleared, and strobes are ignored. After `pwr_dn` is released, no drive appears until a new strobe arrives.
- R8: `stat_pin` selection is decided in this priority order:
  - If `test_mode[0]`=1, `stat_pin` follows `div_tap`.
  - Otherwise, if `test_mode[1]`=1, it carries the lock indication.
  - Otherwise, `stat_sel`=1 selects the lock indication and `stat_sel`=0 selects `carrier_det`.
- R9: While `rst_n` is low, all pump enables are low and the lock indication reads 1 (unlocked).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | 1 | One-cycle strobe per reference edge |
| fb_stb | input | 1 | One-cycle strobe per divided-oscillator edge |
| pwr_dn | input | 1 | Holds the detector idle and unlocked |
| carrier_det | input | 1 | External carrier-detect level |
| stat_sel | input | 1 | 1: lock indication, 0: carrier detect |
| test_mode | input | 2 | Bit 0: divider tap; bit 1: force lock indication |
| div_tap | input | 1 | Divider test signal |
| src_pulse | output | 1 | Source (positive) pump enable |
| snk_pulse | output | 1 | Sink (negative) pump enable |
| drv_en | output | 1 | Pump driven; low means high impedance |
| stat_pin | output | 1 | Multiplexed status output |

## Verification
The assertions take two things for granted about the inputs:
- Both strobes are synchronous to `clk`.
- `pwr_dn` changes only at clock edges.

They do not assume that strobes alternate. A second strobe on the same side while a comparison is open is simply absorbed.

The stimulus drives every input on the falling edge. It then produces these cases:
- simultaneous strobes;
- feedback strobes leading by one or two cycles;
- reference strobes leading by one to four cycles;
- a missing reference;
- a strobe that lands in the clearing cycle;
- power-down in the middle of a pulse.

All status-pin selections are tried with their sources toggled.

// File: rtl/tpfd_pkg.sv
package tpfd_pkg;
  typedef enum logic [1:0] {
    STAT_CARRIER = 2'd0,
    STAT_LOCK    = 2'd1,
    STAT_TAP     = 2'd2
  } stat_src_e;

  function automatic stat_src_e pick_source(input logic [1:0] tmode, input logic sel);
    if (tmode[0])      return STAT_TAP;
    else if (tmode[1]) return STAT_LOCK;
    else if (sel)      return STAT_LOCK;
    else               return STAT_CARRIER;
  endfunction
endpackage

// File: rtl/tpfd_detector.sv
module tpfd_detector (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_stb,
  input  logic fb_stb,
  input  logic pwr_dn,
  output logic src,
  output logic snk,
  output logic drv,
  output logic clr
);
  logic lead_q, lag_q;

  assign clr = lead_q & lag_q;
  assign src = lead_q & ~lag_q;
  assign snk = lag_q & ~lead_q;
  assign drv = src | snk;

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_dn) begin
      lead_q <= 1'b0;
      lag_q  <= 1'b0;
    end else begin
      lead_q <= clr ? ref_stb : (lead_q | ref_stb);
      lag_q  <= clr ? fb_stb  : (lag_q  | fb_stb);
    end
  end

  // R2: a source pulse persists until feedback arrives
  assert_src_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src && !fb_stb && !pwr_dn) |=> src);
  // R1: a sink pulse persists until the reference arrives
  assert_snk_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (snk && !ref_stb && !pwr_dn) |=> snk);
  // R7: power-down idles the pump on the next clock
  assert_pd_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !drv);
endmodule

// File: rtl/tpfd_lock_mon.sv
module tpfd_lock_mon #(
  parameter int MAX_W     = 2,
  parameter int LOCK_RUNS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic drv,
  input  logic clr,
  output logic locked
);
  localparam int WW = $clog2(MAX_W + 2);
  localparam int GW = $clog2(LOCK_RUNS + 1);
  localparam logic [WW-1:0] WMAX = WW'(MAX_W);
  localparam logic [WW-1:0] WSAT = WW'(MAX_W + 1);
  localparam logic [GW-1:0] GMAX = GW'(LOCK_RUNS);

  logic [WW-1:0] wid_q;
  logic [GW-1:0] good_q;

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_dn) begin
      wid_q  <= '0;
      good_q <= '0;
      locked <= 1'b0;
    end else if (clr) begin
      wid_q <= '0;
      if (wid_q <= WMAX) begin
        if (good_q < GMAX) good_q <= good_q + 1'b1;
        if (good_q >= GMAX - 1'b1) locked <= 1'b1;
      end
    end else if (drv) begin
      if (wid_q >= WMAX) begin
        wid_q  <= WSAT;
        good_q <= '0;
        locked <= 1'b0;
      end else begin
        wid_q <= wid_q + 1'b1;
      end
    end
  end

  // R5: lock is only declared at the close of a comparison
  assert_lock_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(clr));
  // R6: lock only falls during a driven cycle or power-down
  assert_lock_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(drv || pwr_dn));
endmodule

// File: rtl/tpfd_status_mux.sv
module tpfd_status_mux
  import tpfd_pkg::*;
(
  input  logic       lock_n,
  input  logic       carrier_det,
  input  logic       stat_sel,
  input  logic [1:0] test_mode,
  input  logic       div_tap,
  output logic       stat_pin
);
  stat_src_e src_sel;

  always_comb begin
    src_sel = pick_source(test_mode, stat_sel);
    unique case (src_sel)
      STAT_TAP:  stat_pin = div_tap;
      STAT_LOCK: stat_pin = lock_n;
      default:   stat_pin = carrier_det;
    endcase
  end
endmodule

// File: rtl/tristate_pfd.sv
module tristate_pfd #(
  parameter int MAX_W     = 2,
  parameter int LOCK_RUNS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_stb,
  input  logic       fb_stb,
  input  logic       pwr_dn,
  input  logic       carrier_det,
  input  logic       stat_sel,
  input  logic [1:0] test_mode,
  input  logic       div_tap,
  output logic       src_pulse,
  output logic       snk_pulse,
  output logic       drv_en,
  output logic       stat_pin
);
  logic clr, locked;

  tpfd_detector u_det (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb), .pwr_dn(pwr_dn),
    .src(src_pulse), .snk(snk_pulse), .drv(drv_en), .clr(clr)
  );

  tpfd_lock_mon #(.MAX_W(MAX_W), .LOCK_RUNS(LOCK_RUNS)) u_lock (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .drv(drv_en), .clr(clr), .locked(locked)
  );

  tpfd_status_mux u_mux (
    .lock_n(~locked), .carrier_det(carrier_det), .stat_sel(stat_sel),
    .test_mode(test_mode), .div_tap(div_tap), .stat_pin(stat_pin)
  );

  // R3: the pump is never driven both ways at once
  assert_no_fight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_pulse && snk_pulse));
endmodule

// File: tb/tristate_pfd_tb.sv
module tristate_pfd_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_stb = 1'b0, fb_stb = 1'b0, pwr_dn = 1'b0;
  logic carrier_det = 1'b0, stat_sel = 1'b1, div_tap = 1'b0;
  logic [1:0] test_mode = 2'b00;
  logic src_pulse, snk_pulse, drv_en, stat_pin;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tristate_pfd u_dut (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb), .pwr_dn(pwr_dn),
    .carrier_det(carrier_det), .stat_sel(stat_sel), .test_mode(test_mode),
    .div_tap(div_tap), .src_pulse(src_pulse), .snk_pulse(snk_pulse),
    .drv_en(drv_en), .stat_pin(stat_pin)
  );

  // behavioural model: pending sides, width so far, run of good comparisons
  bit m_ref, m_fb, m_lock;
  int m_wid, m_good;

  always @(posedge clk) begin
    bit closing;
    closing = m_ref && m_fb;
    if (!rst_n || pwr_dn) begin
      m_ref = 0; m_fb = 0; m_lock = 0; m_wid = 0; m_good = 0;
    end else begin
      if (closing) begin
        if (m_wid <= 2) begin
          m_good = (m_good + 1 > 4) ? 4 : m_good + 1;
          if (m_good >= 4) m_lock = 1;
        end
        m_wid = 0;
        m_ref = ref_stb; m_fb = fb_stb;
      end else begin
        if (m_ref != m_fb) begin
          if (m_wid >= 2) begin m_wid = 3; m_good = 0; m_lock = 0; end
          else m_wid++;
        end
        m_ref = m_ref | ref_stb; m_fb = m_fb | fb_stb;
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_stat();
    if (test_mode[0]) return div_tap;
    if (test_mode[1]) return ~m_lock;
    return stat_sel ? ~m_lock : carrier_det;
  endfunction

  // per-cycle comparison, away from both edges
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk("R2 src_pulse", src_pulse, m_ref && !m_fb);
      chk("R1 snk_pulse", snk_pulse, m_fb && !m_ref);
      chk("R3 drv_en", drv_en, m_ref ^ m_fb);
      chk("R8 stat_pin", stat_pin, exp_stat());
    end
  end

  task automatic cyc(input logic r, input logic f);
    @(negedge clk); ref_stb = r; fb_stb = f;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0);
  endtask
  // lag>0: first strobe then the other lag cycles later
  task automatic pair(input int lag, input bit ref_first);
    if (lag == 0) cyc(1, 1);
    else begin
      if (ref_first) cyc(1, 0); else cyc(0, 1);
      idle(lag - 1);
      if (ref_first) cyc(0, 1); else cyc(1, 0);
    end
    idle(4);
  endtask

  initial begin
    idle(3);
    chk("R9 reset drv", drv_en, 1'b0);
    chk("R9 reset lock_n", stat_pin, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    // R5: four matched comparisons reach lock
    for (int i = 0; i < 4; i++) pair(0, 0);
    chk("R5 locked", stat_pin, 1'b0);
    // R1: feedback leading by 2 keeps lock
    pair(2, 0); pair(1, 0);
    chk("R1 lock kept", stat_pin, 1'b0);
    // R6: reference leading by 4 drops lock
    pair(4, 1);
    chk("R6 unlocked", stat_pin, 1'b1);
    for (int i = 0; i < 3; i++) pair(1, 1);
    chk("R6 run restarted", stat_pin, 1'b1);
    pair(2, 1);
    chk("R5 relocked", stat_pin, 1'b0);
    // R3/R4: strobe landing in clearing cycle
    cyc(1, 1); cyc(1, 0);
    chk("R3 matched hi-z", drv_en, 1'b0);
    cyc(0, 0);
    chk("R4 new comparison", src_pulse, 1'b1);
    cyc(0, 1); idle(3);
    // missing reference
    cyc(0, 1); idle(8);
    chk("R1 long sink unlocks", stat_pin, 1'b1);
    cyc(1, 0); idle(3);
    // R7: power-down mid-pulse, strobes ignored
    for (int i = 0; i < 4; i++) pair(0, 0);
    cyc(1, 0); idle(1);
    @(negedge clk); pwr_dn = 1'b1;
    cyc(1, 0); cyc(0, 1); idle(2);
    chk("R7 pd idle", drv_en, 1'b0);
    chk("R7 pd unlocked", stat_pin, 1'b1);
    @(negedge clk); pwr_dn = 1'b0;
    idle(3);
    chk("R7 no drive after release", drv_en, 1'b0);
    // R8: status selection
    for (int i = 0; i < 4; i++) pair(0, 0);
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 2; s++)
        for (int v = 0; v < 4; v++) begin
          @(negedge clk);
          test_mode = 2'(t); stat_sel = s[0];
          carrier_det = v[0]; div_tap = v[1];
          @(posedge clk); #1;
          chk("R8 select", stat_pin, exp_stat());
        end
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule